// File: doc/BRIEF.md
# Directed Rounding Result Fixup

This unit takes a 64-bit floating-point result that an arithmetic datapath rounded toward nearest or toward zero, and turns it into the result that rounding toward plus infinity or minus infinity would have given. The caller only invokes the unit after it has found that the original rounding was inexact. The unit therefore never checks exactness. It only decides whether the next encoding away from zero is needed, and if so it increments the raw bit pattern.

A start strobe carries three things: the instruction word that produced the result, the result itself, and a direction bit. The instruction word selects one of three layouts. A scalar single uses the low 32-bit word only. A double uses all 64 bits. A paired vector holds two independent 32-bit singles. Instructions that do not belong to this unit, compare-class instructions and unknown layouts are all rejected. A rejected result passes through unchanged with an error flag. One cycle after start, the registered result appears together with a single-cycle done pulse.

Top module: `dirfix_top`

## Requirements
- R1: When `insn[31:26]` is not 4, the unit flags `err` and returns `result_in` unchanged.
- R2: A compare-class instruction has `insn[4:2]` equal to 3'b011 and `insn[1:0]` not equal to 2'b11. Such an instruction is rejected with `err` and the result is returned unchanged.
- R3: `insn[7:5]` selects the layout: 6 is scalar single, 7 is double, 4 is paired vector. Any other value is rejected with `err` and the result is returned unchanged.
- R4: Scalar single: the low word is incremented by one when `round_up`=1 and bit 31 is 0, or when `round_up`=0 and bit 31 is 1. Bits 63:32 pass through unchanged.
- R5: Double: the sign is bit 63. The whole 64-bit value is incremented under the same rule as R4, and the carry propagates from bit 31 into bit 32.
- R6: Paired vector: each 32-bit word is incremented under the R4 rule using its own sign bit (31 or 63). No carry passes between the words, so a word of all ones wraps to zero on its own.
- R7: `result_out` and `err` are registered and update one cycle after `start`. `done` is high exactly in the cycle after each `start` cycle. The outputs hold their values until the next start.
- R8: After reset, `done`, `err` and `result_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe; inputs are sampled in this cycle |
| insn | input | 32 | Instruction word that produced the result |
| result_in | input | 64 | Result as rounded by the datapath |
| round_up | input | 1 | 1 = round toward +infinity, 0 = toward -infinity |
| result_out | output | 64 | Corrected result |
| err | output | 1 | Request was rejected; result_out equals result_in |
| done | output | 1 | One-cycle pulse, one cycle after start |

## Verification
Two things can fall in the same cycle. First, a new start can arrive while the done pulse of the previous request is still high. The bench provokes this with back-to-back strobes of different layouts and directions. It then judges that done stays high for two cycles and that each cycle carries its own request's result. Second, a rejection condition can coincide with an otherwise valid layout, for example a compare code in a double, or a wrong primary opcode with a valid layout field. These cases are judged by checking that the error wins and the data passes through untouched.

// File: rtl/dirfix_pkg.sv
// Shared types and decode constants for the directed rounding fixup.
// Assumes a 32-bit instruction word and a layout field in bits 7:5.
package dirfix_pkg;
    typedef enum logic [1:0] {
        FMT_SGL = 2'd0,
        FMT_DBL = 2'd1,
        FMT_VEC = 2'd2,
        FMT_BAD = 2'd3
    } fix_fmt_e;

    localparam logic [5:0] PRIMARY_OP = 6'd4;
    localparam logic [2:0] SEL_SGL    = 3'd6;
    localparam logic [2:0] SEL_DBL    = 3'd7;
    localparam logic [2:0] SEL_VEC    = 3'd4;
endpackage

// File: rtl/dirfix_decode.sv
// Instruction classifier: finds the layout and decides whether the request
// must be rejected (foreign opcode, compare class, unknown layout).
// Purely combinational; the caller registers the outcome.
module dirfix_decode
    import dirfix_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [2:0] layout,
    input  logic [4:0] func_lo,
    output fix_fmt_e   fmt,
    output logic       reject
);
    logic is_cmp;

    // Map the layout field onto a format and spot compare-class codes.
    always_comb begin
        unique case (layout)
            SEL_SGL: fmt = FMT_SGL;
            SEL_DBL: fmt = FMT_DBL;
            SEL_VEC: fmt = FMT_VEC;
            default: fmt = FMT_BAD;
        endcase
        is_cmp = (func_lo[4:2] == 3'b011) && (func_lo[1:0] != 2'b11);
        reject = (opcode != PRIMARY_OP) || is_cmp || (fmt == FMT_BAD);
    end
endmodule

// File: rtl/dirfix_lane.sv
// One word-wide incrementer with carry in and carry out.
// Assumes the carry in is the only addend.
module dirfix_lane #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Add the carry in and expose the carry out for chaining.
    always_comb begin
        {cout, sum} = {1'b0, a} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/dirfix_adjust.sv
// Computes the adjusted encoding for a legal format. Two lane incrementers
// are steered so that single touches only the low word, double chains the
// carry, and vector bumps each word on its own sign.
module dirfix_adjust
    import dirfix_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0] data,
    input  fix_fmt_e       fmt,
    input  logic           to_pos,
    output logic [2*W-1:0] adj
);
    localparam int LANES = 2;

    logic [LANES-1:0] lane_cin;
    logic [LANES-1:0] lane_cout;
    logic [W-1:0]     lane_sum [LANES];
    logic             bump_lo;
    logic             bump_hi;
    logic             unused_top_carry;

    // Away-from-zero is needed when the direction matches the sign.
    always_comb begin
        bump_lo = to_pos ^ data[W-1];
        bump_hi = to_pos ^ data[2*W-1];
    end

    // Steer carries into the lanes according to the format.
    always_comb begin
        unique case (fmt)
            FMT_SGL: begin lane_cin[0] = bump_lo; lane_cin[1] = 1'b0;         end
            FMT_DBL: begin lane_cin[0] = bump_hi; lane_cin[1] = lane_cout[0]; end
            FMT_VEC: begin lane_cin[0] = bump_lo; lane_cin[1] = bump_hi;      end
            default: begin lane_cin[0] = 1'b0;    lane_cin[1] = 1'b0;         end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dirfix_lane #(.W(W)) lane_i (
            .a    (data[g*W +: W]),
            .cin  (lane_cin[g]),
            .sum  (lane_sum[g]),
            .cout (lane_cout[g])
        );
        assign adj[g*W +: W] = lane_sum[g];
    end

    assign unused_top_carry = lane_cout[LANES-1];
endmodule

// File: rtl/dirfix_top.sv
// Directed rounding fixup top: decodes the instruction, adjusts the result,
// and registers result, error and a one-cycle done pulse.
// Assumes the caller only starts it when the original rounding was inexact.
module dirfix_top
    import dirfix_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [31:0]    insn,
    input  logic [2*W-1:0] result_in,
    input  logic           round_up,
    output logic [2*W-1:0] result_out,
    output logic           err,
    output logic           done
);
    localparam int DW = 2 * W;

    fix_fmt_e        fmt;
    logic            reject;
    logic [DW-1:0]   adj;
    logic            unused_insn;

    assign unused_insn = ^insn[25:8];

    dirfix_decode dec_i (
        .opcode  (insn[31:26]),
        .layout  (insn[7:5]),
        .func_lo (insn[4:0]),
        .fmt     (fmt),
        .reject  (reject)
    );

    dirfix_adjust #(.W(W)) adj_i (
        .data   (result_in),
        .fmt    (fmt),
        .to_pos (round_up),
        .adj    (adj)
    );

    // Capture the outcome of a request and pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_out <= '0;
            err        <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                err        <= reject;
                result_out <= reject ? result_in : adj;
            end
        end
    end

    assert_done_follows_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && $past(rst_n)) |-> done);

    assert_done_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    // Covers R1, R2 and R3: any rejection returns the input untouched.
    assert_reject_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (result_out == $past(result_in)));

    assert_single_upper_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && $past(insn[7:5]) == SEL_SGL)
        |-> (result_out[DW-1:W] == $past(result_in[DW-1:W])));

    assert_double_increment_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && $past(insn[7:5]) == SEL_DBL)
        |-> (result_out == $past(result_in)
             + {{(DW-1){1'b0}}, $past(round_up) ^ $past(result_in[DW-1])}));

    assert_vector_upper_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && $past(insn[7:5]) == SEL_VEC)
        |-> (result_out[DW-1:W] == $past(result_in[DW-1:W])
             + {{(W-1){1'b0}}, $past(round_up) ^ $past(result_in[DW-1])}));
endmodule

// File: tb/dirfix_top_tb_top.sv
module dirfix_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] result_in = '0;
    logic        round_up = 1'b0;
    logic [63:0] result_out;
    logic        err;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dirfix_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
        .result_in(result_in), .round_up(round_up),
        .result_out(result_out), .err(err), .done(done)
    );

    function automatic logic [31:0] mk_insn(input logic [5:0] op, input logic [2:0] lay,
                                            input logic [4:0] fl);
        return {op, 18'h0, lay, fl};
    endfunction

    // Expected behaviour from R1..R6, computed arithmetically.
    function automatic logic [64:0] model(input logic [31:0] i, input logic [63:0] d,
                                          input logic up);
        logic [31:0] lo, hi;
        logic        rej;
        lo = d[31:0];
        hi = d[63:32];
        rej = (i[31:26] != 6'd4) || (i[4:2] == 3'b011 && i[1:0] != 2'b11)
              || !(i[7:5] == 3'd6 || i[7:5] == 3'd7 || i[7:5] == 3'd4);
        if (rej) return {1'b1, d};
        case (i[7:5])
            3'd6:    return {1'b0, hi, lo + ((up != lo[31]) ? 32'd1 : 32'd0)};
            3'd7:    return {1'b0, d + ((up != hi[31]) ? 64'd1 : 64'd0)};
            default: return {1'b0, hi + ((up != hi[31]) ? 32'd1 : 32'd0),
                                   lo + ((up != lo[31]) ? 32'd1 : 32'd0)};
        endcase
    endfunction

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [31:0] i, input logic [63:0] d,
                           input logic up);
        @(negedge clk);
        insn = i; result_in = d; round_up = up; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        insn = '0; result_in = 64'hDEAD_BEEF_DEAD_BEEF;
        check(req, {err, result_out}, model(i, d, up));
        check({req, "_done"}, {64'd0, done}, 65'd1);
        @(negedge clk);
        check({req, "_pulse_R7"}, {64'd0, done}, 65'd0);
    endtask

    logic [31:0] words [8];

    initial begin
        words[0] = 32'h0000_0000; words[1] = 32'h0000_0001;
        words[2] = 32'h7FFF_FFFF; words[3] = 32'h8000_0000;
        words[4] = 32'hFFFF_FFFF; words[5] = 32'h3F80_0000;
        words[6] = 32'hBF80_0000; words[7] = 32'h1234_5678;

        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", {err, result_out}, 65'd0);
        check("R8_done", {64'd0, done}, 65'd0);
        rst_n = 1'b1;

        // R4, R5, R6: sweep word pairs, layouts and directions
        for (int h = 0; h < 8; h++)
            for (int l = 0; l < 8; l++)
                for (int u = 0; u < 2; u++) begin
                    run_one("R4", mk_insn(6'd4, 3'd6, 5'd0), {words[h], words[l]}, u[0]);
                    run_one("R5", mk_insn(6'd4, 3'd7, 5'd0), {words[h], words[l]}, u[0]);
                    run_one("R6", mk_insn(6'd4, 3'd4, 5'd0), {words[h], words[l]}, u[0]);
                end

        // R5 carry across the word boundary; R6 wrap stays inside word
        run_one("R5", mk_insn(6'd4, 3'd7, 5'd1), 64'h0000_0000_FFFF_FFFF, 1'b1);
        run_one("R6", mk_insn(6'd4, 3'd4, 5'd1), 64'h0000_0000_FFFF_FFFF, 1'b0);

        // R1: wrong primary opcode, valid layouts
        for (int o = 0; o < 64; o++)
            if (o != 4) run_one("R1", mk_insn(o[5:0], 3'd7, 5'd0), 64'h0123_4567_89AB_CDEF, 1'b1);

        // R2: all low function codes in each legal layout
        for (int f = 0; f < 32; f++) begin
            run_one("R2", mk_insn(6'd4, 3'd6, f[4:0]), 64'h4000_0000_0000_0005, 1'b1);
            run_one("R2", mk_insn(6'd4, 3'd7, f[4:0]), 64'h8000_0000_0000_0005, 1'b0);
            run_one("R2", mk_insn(6'd4, 3'd4, f[4:0]), 64'h0000_0001_8000_0001, 1'b1);
        end

        // R3: every layout value
        for (int s = 0; s < 8; s++)
            run_one("R3", mk_insn(6'd4, s[2:0], 5'd2), 64'h0000_0010_0000_0020, 1'b1);

        // R7: back-to-back starts, then hold
        @(negedge clk);
        insn = mk_insn(6'd4, 3'd7, 5'd0); result_in = 64'h0000_0000_FFFF_FFFF;
        round_up = 1'b1; start = 1'b1;
        @(negedge clk);
        check("R7_first", {err, result_out}, {1'b0, 64'h0000_0001_0000_0000});
        check("R7_first_done", {64'd0, done}, 65'd1);
        insn = mk_insn(6'd4, 3'd4, 5'd0); result_in = 64'h8000_0000_FFFF_FFFF;
        round_up = 1'b0;
        @(negedge clk);
        start = 1'b0; result_in = 64'h5555_5555_5555_5555;
        check("R7_second", {err, result_out}, {1'b0, 64'h8000_0001_0000_0000});
        check("R7_second_done", {64'd0, done}, 65'd1);
        @(negedge clk);
        @(negedge clk);
        check("R7_hold", {err, result_out}, {1'b0, 64'h8000_0001_0000_0000});
        check("R7_idle", {64'd0, done}, 65'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule